// File: doc/BRIEF.md
# Ternary Deduction Gate

This block models a two-operand Boolean gate in which the two operands and the result are each three-valued: known 0, known 1, or unknown. Any subset of the three values may be supplied on the inputs. The block then fills in every value that the gate function forces, and it echoes every value that was already known. If no Boolean assignment is consistent with the supplied values, it raises a conflict flag instead.

A parameter selects which function is modelled: AND, OR or XOR. The inputs are reduced by combinational logic to a compact deduction state. A register captures that state on each rising clock edge, and a decoder turns the held state into the three predicted values and the flag. Every prediction therefore appears one clock after the inputs that caused it.

Top module: `ternaryDeduceGate`

## Requirements
- R1: Each value is carried on 2 bits: 2'b00 means unknown, 2'b10 means known 0 and 2'b11 means known 1. The input code 2'b01 is treated exactly like unknown. No output ever shows 2'b01.
- R2: The outputs are the deduction for the inputs sampled at the previous rising clock edge. A change on the inputs between edges has no effect on the outputs until the next edge.
- R3: A rising edge with rst_n low makes all three outputs unknown and clears conflict, whatever the inputs are.
- R4: When conflict is low, every input that is known appears unchanged at the matching output.
- R5: With GATE_OP = AND:
  - a known result of 1 forces both operands to 1;
  - a known 0 operand forces the result to 0;
  - an operand of 1 together with a result of 0 forces the other operand to 0.
- R6: With GATE_OP = OR:
  - a known result of 0 forces both operands to 0;
  - a known 1 operand forces the result to 1;
  - an operand of 0 together with a result of 1 forces the other operand to 1.
- R7: With GATE_OP = XOR, any two known values determine the third.
- R8: When no assignment of the unknown positions satisfies the gate, conflict is 1 and all three outputs are unknown.
- R9: A position that is not determined by the known values stays unknown. For example, all-unknown inputs give all-unknown outputs with conflict 0.
- R10: The GATE_OP parameter alone selects the function. The same input triple X,1,1 yields 1,1,1 for AND, X,1,1 for OR and 0,1,1 for XOR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| givenA | input | 2 | First operand as supplied (ternary code) |
| givenB | input | 2 | Second operand as supplied (ternary code) |
| givenY | input | 2 | Gate result as supplied (ternary code) |
| inferA | output | 2 | Deduced first operand |
| inferB | output | 2 | Deduced second operand |
| inferY | output | 2 | Deduced gate result |
| conflict | output | 1 | High when the supplied values are contradictory |

## Verification
The bench focuses on partial assignments where only one position is known, or where the result and one operand are known. In these cases a design that over-deduces would turn an open position into a guess, and one that under-deduces would leave a forced value unknown. It drives contradictory triples, such as a zero operand with a one result under AND, or three ones under XOR; a design that missed them would drop the flag or leak stale predictions. It also feeds the illegal code 2'b01 and compares the same triple across all three gate variants, which catches decoders that read the wrong bit or a map tied to one function. Finally, it applies reset while a conflict is held, and it changes the inputs between edges to catch a design that passes its inputs through without the register.

// File: rtl/tcd_pkg.sv
package tcd_pkg;

  localparam int TRIT_W    = 2;
  localparam int NUM_PAIRS = 4;  // operand assignments (a,b) of a 2-input gate

  typedef logic [TRIT_W-1:0] trit_t;

  localparam trit_t TRIT_X    = 2'b00;
  localparam trit_t TRIT_ZERO = 2'b10;
  localparam trit_t TRIT_ONE  = 2'b11;

  typedef enum logic [1:0] {
    GATE_AND = 2'd0,
    GATE_OR  = 2'd1,
    GATE_XOR = 2'd2
  } gate_e;

  // Held deduction: one fault bit plus the three settled values.
  typedef struct packed {
    logic  fault;
    trit_t tA;
    trit_t tB;
    trit_t tY;
  } deduce_t;

  localparam deduce_t DEDUCE_IDLE = '{fault: 1'b0, tA: TRIT_X, tB: TRIT_X, tY: TRIT_X};

  function automatic logic gateFn(gate_e op, logic a, logic b);
    case (op)
      GATE_AND: return a & b;
      GATE_OR:  return a | b;
      default:  return a ^ b;
    endcase
  endfunction

  // True when a value v is compatible with ternary code t (01 counts as unknown).
  function automatic logic tritAllows(trit_t t, logic v);
    return (~t[1]) | (t[0] == v);
  endfunction

  // Fold the evidence for one position into a ternary code.
  function automatic trit_t foldSeen(logic seen0, logic seen1);
    if (seen1 && !seen0) return TRIT_ONE;
    if (seen0 && !seen1) return TRIT_ZERO;
    return TRIT_X;
  endfunction

endpackage

// File: rtl/tcdMap.sv
module tcdMap
  import tcd_pkg::*;
#(
  parameter gate_e GATE_OP = GATE_AND
) (
  input  trit_t   givenA,
  input  trit_t   givenB,
  input  trit_t   givenY,
  output deduce_t nextState
);

  logic [NUM_PAIRS-1:0] candA;
  logic [NUM_PAIRS-1:0] candB;
  logic [NUM_PAIRS-1:0] candY;
  logic [NUM_PAIRS-1:0] fits;

  // One matcher per full operand assignment; the result bit follows the gate.
  for (genvar i = 0; i < NUM_PAIRS; i++) begin : gPair
    localparam logic CA = ((i >> 1) & 1) != 0;
    localparam logic CB = (i & 1) != 0;
    localparam logic CY = gateFn(GATE_OP, CA, CB);
    assign candA[i] = CA;
    assign candB[i] = CB;
    assign candY[i] = CY;
    assign fits[i]  = tritAllows(givenA, CA) & tritAllows(givenB, CB) & tritAllows(givenY, CY);
  end

  logic seenA0, seenA1, seenB0, seenB1, seenY0, seenY1;

  always_comb begin
    seenA0 = |(fits & ~candA);
    seenA1 = |(fits &  candA);
    seenB0 = |(fits & ~candB);
    seenB1 = |(fits &  candB);
    seenY0 = |(fits & ~candY);
    seenY1 = |(fits &  candY);
    nextState.fault = ~|fits;
    nextState.tA    = foldSeen(seenA0, seenA1);
    nextState.tB    = foldSeen(seenB0, seenB1);
    nextState.tY    = foldSeen(seenY0, seenY1);
  end

endmodule

// File: rtl/tcdStateReg.sv
module tcdStateReg
  import tcd_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  deduce_t nextState,
  output deduce_t curState
);

  always_ff @(posedge clk) begin
    if (!rst_n) curState <= DEDUCE_IDLE;
    else        curState <= nextState;
  end

endmodule

// File: rtl/tcdDecode.sv
module tcdDecode
  import tcd_pkg::*;
(
  input  deduce_t curState,
  output trit_t   inferA,
  output trit_t   inferB,
  output trit_t   inferY,
  output logic    conflict
);

  function automatic trit_t clean(trit_t t, logic blank);
    return (blank || !t[1]) ? TRIT_X : t;
  endfunction

  always_comb begin
    conflict = curState.fault;
    inferA   = clean(curState.tA, curState.fault);
    inferB   = clean(curState.tB, curState.fault);
    inferY   = clean(curState.tY, curState.fault);
  end

endmodule

// File: rtl/ternaryDeduceGate.sv
module ternaryDeduceGate
  import tcd_pkg::*;
#(
  parameter gate_e GATE_OP = GATE_AND
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  givenA,
  input  logic [1:0]  givenB,
  input  logic [1:0]  givenY,
  output logic [1:0]  inferA,
  output logic [1:0]  inferB,
  output logic [1:0]  inferY,
  output logic        conflict
);

  deduce_t nextState;
  deduce_t curState;

  tcdMap #(.GATE_OP(GATE_OP)) uMap (
    .givenA    (givenA),
    .givenB    (givenB),
    .givenY    (givenY),
    .nextState (nextState)
  );

  tcdStateReg uReg (
    .clk       (clk),
    .rst_n     (rst_n),
    .nextState (nextState),
    .curState  (curState)
  );

  tcdDecode uDec (
    .curState (curState),
    .inferA   (inferA),
    .inferB   (inferB),
    .inferY   (inferY),
    .conflict (conflict)
  );

endmodule

// File: rtl/tcdChecker.sv
module tcdChecker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] givenA,
  input logic [1:0] givenB,
  input logic [1:0] givenY,
  input logic [1:0] inferA,
  input logic [1:0] inferB,
  input logic [1:0] inferY,
  input logic       conflict
);

  logic prevRstN;
  always_ff @(posedge clk) prevRstN <= rst_n;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (inferA == 2'b00 && inferB == 2'b00 && inferY == 2'b00 && !conflict)); // R3

  AST_NO_ILLEGAL_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (inferA != 2'b01 && inferB != 2'b01 && inferY != 2'b01)); // R1

  AST_CONFLICT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (inferA == 2'b00 && inferB == 2'b00 && inferY == 2'b00)); // R8

  AST_ECHO_A: assert property (@(posedge clk) disable iff (!rst_n)
    givenA[1] |=> (conflict || inferA == $past(givenA))); // R4

  AST_ECHO_B: assert property (@(posedge clk) disable iff (!rst_n)
    givenB[1] |=> (conflict || inferB == $past(givenB))); // R4

  AST_ECHO_Y: assert property (@(posedge clk) disable iff (!rst_n)
    givenY[1] |=> (conflict || inferY == $past(givenY))); // R4

  AST_HELD_INPUTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prevRstN == 1'b1 && $stable(givenA) && $stable(givenB) && $stable(givenY))
      |=> $stable({inferA, inferB, inferY, conflict})); // R2

endmodule

bind ternaryDeduceGate tcdChecker uChk (
  .clk      (clk),
  .rst_n    (rst_n),
  .givenA   (givenA),
  .givenB   (givenB),
  .givenY   (givenY),
  .inferA   (inferA),
  .inferB   (inferB),
  .inferY   (inferY),
  .conflict (conflict)
);

// File: tb/ternaryDeduceGate_test.sv
`timescale 1ns/1ps
module ternaryDeduceGate_test;
  import tcd_pkg::*;

  localparam logic [1:0] X = 2'b00, Z = 2'b10, O = 2'b11, BAD = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] gA [3];
  logic [1:0] gB [3];
  logic [1:0] gY [3];
  logic [1:0] oA [3];
  logic [1:0] oB [3];
  logic [1:0] oY [3];
  logic       oC [3];

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ternaryDeduceGate #(.GATE_OP(GATE_AND)) uut (
    .clk(clk), .rst_n(rst_n), .givenA(gA[0]), .givenB(gB[0]), .givenY(gY[0]),
    .inferA(oA[0]), .inferB(oB[0]), .inferY(oY[0]), .conflict(oC[0]));
  ternaryDeduceGate #(.GATE_OP(GATE_OR)) uutOr (
    .clk(clk), .rst_n(rst_n), .givenA(gA[1]), .givenB(gB[1]), .givenY(gY[1]),
    .inferA(oA[1]), .inferB(oB[1]), .inferY(oY[1]), .conflict(oC[1]));
  ternaryDeduceGate #(.GATE_OP(GATE_XOR)) uutXor (
    .clk(clk), .rst_n(rst_n), .givenA(gA[2]), .givenB(gB[2]), .givenY(gY[2]),
    .inferA(oA[2]), .inferB(oB[2]), .inferY(oY[2]), .conflict(oC[2]));

  typedef struct {
    int         gate;
    logic [1:0] a, b, y;
    logic       c;
    string      tag;
  } exp_t;

  exp_t sb[$];

  task automatic compareNow(input int g, input logic [1:0] ea, eb, ey, input logic ec,
                            input string tag);
    testsRun++;
    if (oA[g] !== ea || oB[g] !== eb || oY[g] !== ey || oC[g] !== ec) begin
      testsFailed++;
      $display("FAIL %s gate%0d: got %b %b %b c=%b, expected %b %b %b c=%b",
               tag, g, oA[g], oB[g], oY[g], oC[g], ea, eb, ey, ec);
    end
  endtask

  // Driver: apply inputs at a falling edge, queue the expectation after the capturing edge.
  task automatic step(input int g, input logic [1:0] a, b, y, input logic rstVal,
                      input logic [1:0] ea, eb, ey, input logic ec, input string tag);
    exp_t it;
    gA[g] = a; gB[g] = b; gY[g] = y; rst_n = rstVal;
    @(posedge clk);
    it.gate = g; it.a = ea; it.b = eb; it.y = ey; it.c = ec; it.tag = tag;
    sb.push_back(it);
    @(negedge clk);
  endtask

  // Monitor: outputs are settled by the falling edge after the capturing edge.
  always @(negedge clk) begin
    exp_t it;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      compareNow(it.gate, it.a, it.b, it.y, it.c, it.tag);
    end
  end

  initial begin
    for (int g = 0; g < 3; g++) begin
      gA[g] = O; gB[g] = BAD; gY[g] = Z;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int g = 0; g < 3; g++) compareNow(g, X, X, X, 1'b0, "R3 reset state");

    // AND gate
    step(0, X, X, X, 1'b1, X, X, X, 1'b0, "R9 and all unknown");
    gY[0] = O;
    #1 compareNow(0, X, X, X, 1'b0, "R2 no change before edge");
    step(0, X, X, O, 1'b1, O, O, O, 1'b0, "R5 and result one");
    step(0, X, Z, X, 1'b1, X, Z, Z, 1'b0, "R5 and zero operand");
    step(0, O, X, Z, 1'b1, O, Z, Z, 1'b0, "R5 and one with zero result");
    step(0, X, O, X, 1'b1, X, O, X, 1'b0, "R9 and b one stays open");
    step(0, BAD, O, X, 1'b1, X, O, X, 1'b0, "R1 illegal code as unknown");
    step(0, Z, O, Z, 1'b1, Z, O, Z, 1'b0, "R4 full consistent echo");
    step(0, Z, X, O, 1'b1, X, X, X, 1'b1, "R8 and zero with one result");
    step(0, O, O, Z, 1'b1, X, X, X, 1'b1, "R8 and ones with zero result");
    step(0, O, O, O, 1'b0, X, X, X, 1'b0, "R3 reset over held conflict");
    step(0, O, O, O, 1'b1, O, O, O, 1'b0, "R4 after reset release");

    // OR gate
    step(1, X, X, Z, 1'b1, Z, Z, Z, 1'b0, "R6 or result zero");
    step(1, O, X, X, 1'b1, O, X, O, 1'b0, "R6 or one operand");
    step(1, Z, X, O, 1'b1, Z, O, O, 1'b0, "R6 or zero with one result");
    step(1, O, Z, X, 1'b1, O, Z, O, 1'b0, "R6 or one zero");
    step(1, X, X, O, 1'b1, X, X, O, 1'b0, "R9 or result one open");
    step(1, O, X, Z, 1'b1, X, X, X, 1'b1, "R8 or one with zero result");

    // XOR gate
    step(2, O, X, O, 1'b1, O, Z, O, 1'b0, "R7 xor solve b");
    step(2, X, O, Z, 1'b1, O, O, Z, 1'b0, "R7 xor solve a");
    step(2, Z, O, X, 1'b1, Z, O, O, 1'b0, "R7 xor solve y");
    step(2, X, Z, X, 1'b1, X, Z, X, 1'b0, "R9 xor single known");
    step(2, O, O, BAD, 1'b1, O, O, Z, 1'b0, "R1 illegal result as unknown");
    step(2, O, O, O, 1'b1, X, X, X, 1'b1, "R8 xor all ones");

    // Same triple on every variant
    step(0, X, O, O, 1'b1, O, O, O, 1'b0, "R10 and variant");
    step(1, X, O, O, 1'b1, X, O, O, 1'b0, "R10 or variant");
    step(2, X, O, O, 1'b1, Z, O, O, 1'b0, "R10 xor variant");

    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule